// File: doc/BRIEF.md
# Fat-Tree Circuit Path Reservation Controller

This block is the single central decision point for a circuit-switched fat-tree network. Each leaf of the tree is a concentrator that serves four cores, so a network of k cores has k/4 leaves and log2(k/4) router levels. A leaf that wants to send asks for a circuit to a destination leaf. The controller works out the minimal turnaround route: the path climbs from the source to the lowest common ancestor, turns there, and descends to the destination. It then either reserves every link of that route in one step and answers GRANT, or reserves nothing and answers DENY. A later release message frees the circuit.

Several requester ports share one valid/ready interface. A rotating-priority arbiter accepts one message per cycle. Every open request gets its answer a fixed number of cycles after it is accepted. The link occupancy vectors double as the switch-setting outputs for the routers. A per-leaf transmit enable is raised only while that leaf is the source of a granted circuit.

Top module: `fatTreeCircuitCtrl`

## Requirements
- R1: Link bit l*NL + (leaf >> l) of `upBusy` is the upward link that leaves level-l node (leaf >> l), and the same bit of `downBusy` is the downward link that enters it. Let t be the most significant set bit of src XOR dst. A granted open from src to dst sets the `upBusy` bits of src and the `downBusy` bits of dst for levels 0..t, and no other bits.
- R2: An open whose source equals its destination is answered with DENY (`respGrant`=0) and changes no occupancy, transmit or error state.
- R3: An open that needs any link already marked busy is answered with DENY and leaves all occupancy and transmit state unchanged.
- R4: An open accepted on clock edge n (`reqValid` and `reqReady` both high) produces `respValid` high for exactly one cycle, set by edge n+1. `respPort` names the accepting port and `respGrant` is 1 for GRANT and 0 for DENY. Releases produce no response.
- R5: A release (`reqKind`=1) naming a source leaf together with the destination of that leaf's live circuit clears exactly that circuit's upward and downward link bits. These changes are visible after edge n+1.
- R6: A release naming a circuit that does not exist sets `tearErr`. The flag stays set until reset, and the release changes nothing else.
- R7: `txEnable[i]` is high exactly while leaf i is the source of a granted, unreleased circuit.
- R8: At most one port is ready in any cycle, and only a port with `reqValid` high. When several are valid, the search for the ready port starts at the port after the one accepted last.
- R9: After reset all links are free, every transmit enable is low, `tearErr` and `respValid` are low, and the arbiter starts at port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | NP | Per-port message valid |
| reqKind | input | NP | Per-port message type: 0 open, 1 release |
| reqSrc | input | NP*LW | Per-port source leaf, LW bits per port |
| reqDst | input | NP*LW | Per-port destination leaf, LW bits per port |
| reqReady | output | NP | One-hot acceptance strobe |
| respValid | output | 1 | Answer to an open is present |
| respGrant | output | 1 | 1 GRANT, 0 DENY |
| respPort | output | PW | Port that issued the answered open |
| upBusy | output | LW*NL | Upward link reservations / switch settings |
| downBusy | output | LW*NL | Downward link reservations / switch settings |
| txEnable | output | NL | Per-leaf transmitter enable |
| tearErr | output | 1 | Sticky flag for a release of a non-existent circuit |

## Verification
The checker watches several properties on every cycle:
- the ready vector is one-hot among the valid ports;
- every answer follows an acceptance two edges earlier;
- a DENY leaves both occupancy vectors untouched, and a GRANT increases them;
- the numbers of reserved upward and downward links are always equal;
- transmit enables track the level-0 upward links;
- the error flag never drops.

Only the bench's scenarios can show that the correct links are chosen. For that, it sweeps every source and destination pair on an empty tree, runs deliberate conflicts and interleaved random opens and releases against an arithmetic occupancy model, sends concurrent requests to observe the rotation order, and checks that a bad release leaves every other output unchanged.

// File: rtl/fatTreePkg.sv
package fatTreePkg;
  typedef enum logic {KIND_OPEN = 1'b0, KIND_CLOSE = 1'b1} reqKindE;

  typedef struct packed {
    logic load;     // capture the arbitrated message into the stage
    logic doTake;   // reserve the staged route
    logic doFree;   // release the staged route
    logic setErr;   // release of a non-existent circuit
    logic respond;  // answer the staged open
  } ctrlStrobeT;
endpackage

// File: rtl/ftCtrl.sv
module ftCtrl
  import fatTreePkg::*;
#(
  parameter int NP = 2,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] reqValid,
  input  logic [NP-1:0] reqKind,
  input  logic          pathOk,
  input  logic          pathOwned,
  output logic [NP-1:0] reqReady,
  output logic [PW-1:0] pickIdx,
  output ctrlStrobeT    strb
);
  logic [PW-1:0] rrPtr;
  logic          anyPick;
  logic          stgValid;
  logic          stgKind;

  // rotating-priority search; the lowest offset from rrPtr wins
  always_comb begin
    int idx;
    anyPick = 1'b0;
    pickIdx = '0;
    for (int off = NP - 1; off >= 0; off--) begin
      idx = (int'(rrPtr) + off) % NP;
      if (reqValid[idx]) begin
        anyPick = 1'b1;
        pickIdx = PW'(idx);
      end
    end
  end

  always_comb begin
    reqReady = '0;
    if (!rst && anyPick) reqReady[pickIdx] = 1'b1;
  end

  always_comb begin
    strb.load    = anyPick && !rst;
    strb.doTake  = stgValid && (stgKind == KIND_OPEN) && pathOk;
    strb.doFree  = stgValid && (stgKind == KIND_CLOSE) && pathOwned;
    strb.setErr  = stgValid && (stgKind == KIND_CLOSE) && !pathOwned;
    strb.respond = stgValid && (stgKind == KIND_OPEN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rrPtr    <= '0;
      stgValid <= 1'b0;
      stgKind  <= 1'b0;
    end else begin
      stgValid <= anyPick;
      if (anyPick) begin
        stgKind <= reqKind[pickIdx];
        rrPtr   <= (pickIdx == PW'(NP - 1)) ? '0 : pickIdx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ftDatapath.sv
module ftDatapath
  import fatTreePkg::*;
#(
  parameter int NL = 16,
  parameter int NP = 2,
  localparam int LW = $clog2(NL),
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ctrlStrobeT             strb,
  input  logic [PW-1:0]          pickIdx,
  input  logic [NP*LW-1:0]       reqSrc,
  input  logic [NP*LW-1:0]       reqDst,
  output logic                   pathOk,
  output logic                   pathOwned,
  output logic [LW-1:0][NL-1:0]  upBusy,
  output logic [LW-1:0][NL-1:0]  downBusy,
  output logic [NL-1:0]          txEnable,
  output logic                   respValid,
  output logic                   respGrant,
  output logic [PW-1:0]          respPort,
  output logic                   tearErr
);
  logic [LW-1:0] stgSrc, stgDst, diff, levelUsed;
  logic [PW-1:0] stgPort;
  logic [NL-1:0] srcActive;
  logic [LW-1:0] srcDest [NL];

  assign diff = stgSrc ^ stgDst;

  // a level is on the route when the leaves still differ at or above it
  for (genvar g = 0; g < LW; g++) begin : gLvl
    assign levelUsed[g] = |(diff >> g);
  end

  always_comb begin
    pathOk = |diff;
    for (int l = 0; l < LW; l++) begin
      if (levelUsed[l] && (upBusy[l][stgSrc >> l] || downBusy[l][stgDst >> l]))
        pathOk = 1'b0;
    end
  end

  assign pathOwned = srcActive[stgSrc] && (srcDest[stgSrc] == stgDst);
  assign txEnable  = srcActive;

  always_ff @(posedge clk) begin
    if (rst) begin
      stgSrc    <= '0;
      stgDst    <= '0;
      stgPort   <= '0;
      upBusy    <= '0;
      downBusy  <= '0;
      srcActive <= '0;
      tearErr   <= 1'b0;
      respValid <= 1'b0;
      respGrant <= 1'b0;
      respPort  <= '0;
      for (int i = 0; i < NL; i++) srcDest[i] <= '0;
    end else begin
      if (strb.load) begin
        stgSrc  <= reqSrc[pickIdx*LW +: LW];
        stgDst  <= reqDst[pickIdx*LW +: LW];
        stgPort <= pickIdx;
      end
      for (int l = 0; l < LW; l++) begin
        if (levelUsed[l] && strb.doTake) begin
          upBusy[l][stgSrc >> l]   <= 1'b1;
          downBusy[l][stgDst >> l] <= 1'b1;
        end else if (levelUsed[l] && strb.doFree) begin
          upBusy[l][stgSrc >> l]   <= 1'b0;
          downBusy[l][stgDst >> l] <= 1'b0;
        end
      end
      if (strb.doTake) begin
        srcActive[stgSrc] <= 1'b1;
        srcDest[stgSrc]   <= stgDst;
      end else if (strb.doFree) begin
        srcActive[stgSrc] <= 1'b0;
      end
      if (strb.setErr) tearErr <= 1'b1;
      respValid <= strb.respond;
      respGrant <= strb.doTake;
      if (strb.respond) respPort <= stgPort;
    end
  end
endmodule

// File: rtl/fatTreeCircuitCtrl.sv
module fatTreeCircuitCtrl
  import fatTreePkg::*;
#(
  parameter int NL = 16,
  parameter int NP = 2,
  localparam int LW = $clog2(NL),
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NP-1:0]    reqValid,
  input  logic [NP-1:0]    reqKind,
  input  logic [NP*LW-1:0] reqSrc,
  input  logic [NP*LW-1:0] reqDst,
  output logic [NP-1:0]    reqReady,
  output logic             respValid,
  output logic             respGrant,
  output logic [PW-1:0]    respPort,
  output logic [LW*NL-1:0] upBusy,
  output logic [LW*NL-1:0] downBusy,
  output logic [NL-1:0]    txEnable,
  output logic             tearErr
);
  ctrlStrobeT    strb;
  logic [PW-1:0] pickIdx;
  logic          pathOk, pathOwned;
  logic [LW-1:0][NL-1:0] upVec, downVec;

  ftCtrl #(.NP(NP)) i_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqKind(reqKind),
    .pathOk(pathOk), .pathOwned(pathOwned), .reqReady(reqReady),
    .pickIdx(pickIdx), .strb(strb)
  );

  ftDatapath #(.NL(NL), .NP(NP)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .pickIdx(pickIdx),
    .reqSrc(reqSrc), .reqDst(reqDst), .pathOk(pathOk), .pathOwned(pathOwned),
    .upBusy(upVec), .downBusy(downVec), .txEnable(txEnable),
    .respValid(respValid), .respGrant(respGrant), .respPort(respPort),
    .tearErr(tearErr)
  );

  assign upBusy   = upVec;
  assign downBusy = downVec;
endmodule

// File: rtl/fatTreeCircuitCtrlChk.sv
module fatTreeCircuitCtrlChk #(
  parameter int NL = 16,
  parameter int NP = 2,
  localparam int LW = $clog2(NL)
) (
  input logic             clk,
  input logic             rst,
  input logic [NP-1:0]    reqValid,
  input logic [NP-1:0]    reqReady,
  input logic             respValid,
  input logic             respGrant,
  input logic [LW*NL-1:0] upBusy,
  input logic [LW*NL-1:0] downBusy,
  input logic [NL-1:0]    txEnable,
  input logic             tearErr
);
  // R8
  ready_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reqReady) && ((reqReady & ~reqValid) == '0));

  // R4
  resp_latency_chk: assert property (@(posedge clk) disable iff (rst)
    respValid |-> $past(|(reqValid & reqReady), 2));

  // R3
  deny_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (respValid && !respGrant) |-> ($stable(upBusy) && $stable(downBusy)));

  // R1
  grant_grows_chk: assert property (@(posedge clk) disable iff (rst)
    (respValid && respGrant) |-> ($countones(upBusy) > $countones($past(upBusy))));

  // R5
  link_balance_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(upBusy) == $countones(downBusy));

  // R7
  tx_owner_chk: assert property (@(posedge clk) disable iff (rst)
    txEnable == upBusy[NL-1:0]);

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(tearErr) |-> tearErr);
endmodule

bind fatTreeCircuitCtrl fatTreeCircuitCtrlChk #(.NL(NL), .NP(NP)) i_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
  .respValid(respValid), .respGrant(respGrant), .upBusy(upBusy),
  .downBusy(downBusy), .txEnable(txEnable), .tearErr(tearErr)
);

// File: tb/test_fatTreeCircuitCtrl.sv
module test_fatTreeCircuitCtrl;
  localparam int NL = 16;
  localparam int NP = 2;
  localparam int LW = 4;
  localparam int PW = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0]    reqValid = '0;
  logic [NP-1:0]    reqKind = '0;
  logic [NP*LW-1:0] reqSrc = '0;
  logic [NP*LW-1:0] reqDst = '0;
  logic [NP-1:0]    reqReady;
  logic             respValid, respGrant;
  logic [PW-1:0]    respPort;
  logic [LW*NL-1:0] upBusy, downBusy;
  logic [NL-1:0]    txEnable;
  logic             tearErr;

  always #2.5 clk = ~clk;

  fatTreeCircuitCtrl #(.NL(NL), .NP(NP)) i_fatTreeCircuitCtrl (.*);

  int nChecks = 0;
  int nFails  = 0;

  // occupancy model kept by the bench
  logic [LW-1:0][NL-1:0] mUp, mDown;
  logic [NL-1:0] mAct;
  logic [LW-1:0] mDst [NL];
  logic mErr;
  int   mPtr;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit expOk(input int s, input int d);
    bit ok;
    int x;
    x = s ^ d;
    ok = (x != 0);
    for (int l = 0; l < LW; l++)
      if ((x >> l) != 0 && (mUp[l][s >> l] || mDown[l][d >> l])) ok = 0;
    return ok;
  endfunction

  task automatic modelSet(input int s, input int d, input bit val);
    int x;
    x = s ^ d;
    for (int l = 0; l < LW; l++)
      if ((x >> l) != 0) begin
        mUp[l][s >> l]   = val;
        mDown[l][d >> l] = val;
      end
    mAct[s] = val;
    if (val) mDst[s] = LW'(d);
  endtask

  task automatic checkState(input string tag);
    check(tag, 64'(upBusy), 64'(mUp));
    check(tag, 64'(downBusy), 64'(mDown));
    check("R7 txEnable", 64'(txEnable), 64'(mAct));
    check("R6 tearErr", 64'(tearErr), 64'(mErr));
  endtask

  // single message on one port; the answer is sampled after the edge that follows acceptance
  task automatic issue(input int p, input bit k, input int s, input int d,
                       output bit gotResp, output bit gotGrant, output int gotPort);
    @(negedge clk);
    reqValid[p] = 1'b1;
    reqKind[p]  = k;
    reqSrc[p*LW +: LW] = LW'(s);
    reqDst[p*LW +: LW] = LW'(d);
    #1;
    check("R8 ready single", 64'(reqReady), 64'(1 << p));
    @(posedge clk);
    mPtr = (p + 1) % NP;
    @(negedge clk);
    reqValid[p] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    gotResp  = respValid;
    gotGrant = respGrant;
    gotPort  = int'(respPort);
  endtask

  task automatic doOpen(input int p, input int s, input int d);
    bit r, g, ok;
    int pp;
    ok = expOk(s, d);
    issue(p, 1'b0, s, d, r, g, pp);
    check("R4 respValid", 64'(r), 64'd1);
    check("R4 respPort", 64'(pp), 64'(p));
    if (s == d) check("R2 self deny", 64'(g), 64'd0);
    else if (ok) check("R1 grant", 64'(g), 64'd1);
    else check("R3 busy deny", 64'(g), 64'd0);
    if (ok) modelSet(s, d, 1'b1);
    checkState(ok ? "R1 links" : "R3 links unchanged");
  endtask

  task automatic doClose(input int p, input int s, input int d);
    bit r, g, owned;
    int pp;
    owned = mAct[s] && (int'(mDst[s]) == d);
    issue(p, 1'b1, s, d, r, g, pp);
    check("R4 no response to release", 64'(r), 64'd0);
    if (owned) modelSet(s, d, 1'b0);
    else mErr = 1'b1;
    checkState(owned ? "R5 links freed" : "R6 links unchanged");
  endtask

  // both ports valid together; priority starts at mPtr
  task automatic pairTest(input int sa, input int da, input int sb, input int db);
    int first, second;
    bit okF, okS;
    int sF, dF, sS, dS;
    first = mPtr; second = (mPtr + 1) % NP;
    @(negedge clk);
    reqValid = '1; reqKind = '0;
    reqSrc[0 +: LW] = LW'(sa); reqDst[0 +: LW] = LW'(da);
    reqSrc[LW +: LW] = LW'(sb); reqDst[LW +: LW] = LW'(db);
    #1;
    check("R8 rotating pick first", 64'(reqReady), 64'(1 << first));
    @(posedge clk);
    @(negedge clk);
    reqValid[first] = 1'b0;
    #1;
    check("R8 rotating pick second", 64'(reqReady), 64'(1 << second));
    @(posedge clk);
    mPtr = (second + 1) % NP;
    @(negedge clk);
    reqValid[second] = 1'b0;
    sF = (first == 0) ? sa : sb; dF = (first == 0) ? da : db;
    sS = (first == 0) ? sb : sa; dS = (first == 0) ? db : da;
    okF = expOk(sF, dF);
    if (okF) modelSet(sF, dF, 1'b1);
    check("R4 first answer valid", 64'(respValid), 64'd1);
    check("R8 first answer port", 64'(respPort), 64'(first));
    check("R1 first answer grant", 64'(respGrant), 64'(okF));
    @(posedge clk);
    @(negedge clk);
    okS = expOk(sS, dS);
    if (okS) modelSet(sS, dS, 1'b1);
    check("R4 second answer valid", 64'(respValid), 64'd1);
    check("R8 second answer port", 64'(respPort), 64'(second));
    check("R3 second answer grant", 64'(respGrant), 64'(okS));
    checkState("R1 pair links");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    mUp = '0; mDown = '0; mAct = '0; mErr = 1'b0; mPtr = 0;
    for (int i = 0; i < NL; i++) mDst[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 reset state
    check("R9 respValid", 64'(respValid), 64'd0);
    check("R9 upBusy", 64'(upBusy), 64'd0);
    check("R9 downBusy", 64'(downBusy), 64'd0);
    check("R9 txEnable", 64'(txEnable), 64'd0);
    check("R9 tearErr", 64'(tearErr), 64'd0);
    check("R9 ready idle", 64'(reqReady), 64'd0);

    // exhaustive pair sweep on an empty tree
    for (int s = 0; s < NL; s++)
      for (int d = 0; d < NL; d++) begin
        doOpen((s + d) % NP, s, d);
        if (s != d) doClose((s + d + 1) % NP, s, d);
      end

    // deliberate conflicts
    doOpen(0, 0, 15);
    doOpen(1, 1, 14);   // shares an upward link at level 1
    doOpen(0, 2, 3);
    doOpen(1, 3, 2);
    doOpen(0, 15, 0);
    doOpen(1, 4, 15);   // destination downward link at level 0 busy
    doClose(0, 0, 15);
    doOpen(1, 1, 14);
    doClose(1, 1, 14);
    doClose(0, 2, 3);
    doClose(1, 3, 2);
    doClose(0, 15, 0);

    // concurrent requests and rotation
    pairTest(4, 5, 6, 7);
    pairTest(8, 12, 9, 13);
    pairTest(10, 11, 10, 1);  // same source: second is denied

    // release of a circuit that does not exist
    doClose(0, 5, 6);
    doClose(1, 4, 6);         // wrong destination for a live source

    // random interleaving
    for (int n = 0; n < 400; n++) begin
      int s, d, p;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      p = int'(lfsr[0]);
      s = int'(lfsr[7:4]);
      d = int'(lfsr[11:8]);
      if (lfsr[1] && lfsr[2]) begin
        if (lfsr[3] && mAct[s]) d = int'(mDst[s]);
        doClose(p, s, d);
      end else begin
        doOpen(p, s, d);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule